// File: doc/BRIEF.md
# Lane Code Group Synchronizer

This block is the receive-side synchronization controller for one lane of a serial converter link. It takes one decoded 8b/10b character per clock, with a flag that marks control characters and a flag that marks characters the decoder rejected (not in the code table or a disparity fault). It drives the active-low synchronization request back to the transmitter. It releases that request only after a clean run of comma characters, and it asserts the request again when the lane starts to show decoder errors.

The controller has three named states. `ST_HUNT` holds the request low and waits for the first comma. `ST_COUNT` counts consecutive commas. `ST_LOCKED` holds the request high. The transitions are: HUNT→COUNT on a comma; COUNT→COUNT on a further comma; COUNT→HUNT on any other character; HUNT→LOCKED or COUNT→LOCKED on the comma that completes the required run; LOCKED→HUNT when three of the last four characters were decoder errors; any state→HUNT while the link enable is low.

While the controller is locked, it flags the first clean non-comma character that arrives on a local multi-frame boundary with a one-cycle pulse. That pulse marks the start of the lane alignment sequence. A saturating counter totals the decoder errors seen while the link is enabled.

Top module: `cgs_lane_sync`

## Requirements
- R1: After reset, and on the cycle after any cycle with `link_en` low, `sync_n` is 0, `cgs_locked` is 0 and `ilas_start` is 0. Reset clears `err_count` to 0.
- R2: A character counts as a comma only when `rx_ctrl`=1, `rx_char`=8'hBC and `rx_err`=0. The same byte with `rx_ctrl`=0 is plain data.
- R3: `sync_n` and `cgs_locked` go to 1 on the cycle after the fourth consecutive comma, counting from the first comma seen in HUNT. They stay 0 after only three commas.
- R4: Before lock, any character that is not a comma sends the controller back to HUNT, so the comma run must start again from zero.
- R5: When locked, commas and clean data characters keep `sync_n` at 1.
- R6: When locked, if the current character and the three before it include at least three decoder errors, `sync_n` and `cgs_locked` drop to 0 on the next cycle. Two errors in any four characters do not drop the lock.
- R7: `ilas_start` is a one-cycle pulse. It is raised on the cycle after the first clean non-comma character that arrives, while locked, in the same cycle as `lmfc_edge`. It fires at most once per locked interval. A clean non-comma character away from a boundary raises no pulse.
- R8: Each character with `rx_err`=1 received while `link_en`=1 adds one to `err_count` on the next cycle. The count saturates at its maximum value and holds while `link_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Link enable; low forces the hunt state |
| rx_char | input | 8 | Decoded character byte |
| rx_ctrl | input | 1 | Character is a control character |
| rx_err | input | 1 | Decoder error (not in table or disparity) |
| lmfc_edge | input | 1 | Local multi-frame boundary pulse |
| sync_n | output | 1 | Active-low synchronization request |
| cgs_locked | output | 1 | Code groups synchronized |
| ilas_start | output | 1 | One-cycle start-of-alignment-sequence pulse |
| err_count | output | ERR_W | Saturating decoder error total |

## Verification
Each output is registered once behind its inputs. `sync_n`, `cgs_locked`, `ilas_start` and `err_count` all show the effect of a character one clock after that character is presented. The bench drives every character on a falling edge and waits through one rising edge. It advances its own reference model with the same character and compares all four outputs on the next falling edge. Because of this, the fourth-comma release, the three-in-four drop and the boundary pulse are each checked in exactly the cycle the requirements give.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_LOCKED = 2'd2
    } cgs_state_e;

    typedef struct packed {
        logic comma;
        logic bad;
        logic clean_data;
    } char_class_t;

endpackage

// File: rtl/cgs_char_class.sv
module cgs_char_class
    import cgs_pkg::*;
#(
    parameter logic [7:0] COMMA_BYTE = 8'hBC
) (
    input  logic [7:0]  char_i,
    input  logic        ctrl_i,
    input  logic        err_i,
    output char_class_t cls_o
);
    always_comb begin
        cls_o.bad        = err_i;
        cls_o.comma      = ctrl_i && (char_i == COMMA_BYTE) && !err_i;
        cls_o.clean_data = !err_i && !(ctrl_i && (char_i == COMMA_BYTE));
    end
endmodule

// File: rtl/cgs_sat_counter.sv
module cgs_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != CMAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/cgs_err_window.sv
module cgs_err_window #(
    parameter int WIN    = 4,
    parameter int THRESH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic push_i,
    input  logic bad_i,
    output logic trip_o
);
    localparam int HW = WIN - 1;

    logic [HW-1:0] hist_q;
    int            hits;

    always_comb begin
        hits   = $countones(hist_q) + (bad_i ? 1 : 0);
        trip_o = push_i && (hits >= THRESH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr_i || trip_o) begin
            hist_q <= '0;
        end else if (push_i) begin
            hist_q <= {hist_q[HW-2:0], bad_i};
        end
    end
endmodule

// File: rtl/cgs_lane_sync.sv
module cgs_lane_sync
    import cgs_pkg::*;
#(
    parameter int         NEED       = 4,
    parameter int         WIN        = 4,
    parameter int         THRESH     = 3,
    parameter int         ERR_W      = 8,
    parameter logic [7:0] COMMA_BYTE = 8'hBC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_en,
    input  logic [7:0]       rx_char,
    input  logic             rx_ctrl,
    input  logic             rx_err,
    input  logic             lmfc_edge,
    output logic             sync_n,
    output logic             cgs_locked,
    output logic             ilas_start,
    output logic [ERR_W-1:0] err_count
);
    localparam int              RUN_W    = $clog2(NEED + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(NEED - 1);

    cgs_state_e  state_q, state_d;
    char_class_t cls;
    logic [RUN_W-1:0] run_cnt;
    logic        run_clr, run_inc;
    logic        trip;
    logic        in_lock;
    logic        seen_q;
    logic        pulse_d;
    logic        sync_n_q, locked_q, ilas_q;

    cgs_char_class #(.COMMA_BYTE(COMMA_BYTE)) u_class (
        .char_i (rx_char),
        .ctrl_i (rx_ctrl),
        .err_i  (rx_err),
        .cls_o  (cls)
    );

    // consecutive comma run used before lock
    cgs_sat_counter #(.W(RUN_W)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (run_clr),
        .inc_i (run_inc),
        .cnt_o (run_cnt)
    );

    // decoder error totals
    cgs_sat_counter #(.W(ERR_W)) u_errs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (1'b0),
        .inc_i (link_en && cls.bad),
        .cnt_o (err_count)
    );

    assign in_lock = (state_q == ST_LOCKED);

    cgs_err_window #(.WIN(WIN), .THRESH(THRESH)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!in_lock || !link_en),
        .push_i (in_lock && link_en),
        .bad_i  (cls.bad),
        .trip_o (trip)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        run_clr = 1'b0;
        run_inc = 1'b0;
        if (!link_en) begin
            state_d = ST_HUNT;
            run_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_HUNT, ST_COUNT: begin
                    if (cls.comma) begin
                        if (run_cnt == RUN_LAST) begin
                            state_d = ST_LOCKED;
                            run_clr = 1'b1;
                        end else begin
                            state_d = ST_COUNT;
                            run_inc = 1'b1;
                        end
                    end else begin
                        state_d = ST_HUNT;
                        run_clr = 1'b1;
                    end
                end
                ST_LOCKED: begin
                    run_clr = 1'b1;
                    if (trip) begin
                        state_d = ST_HUNT;
                    end
                end
                default: begin
                    state_d = ST_HUNT;
                    run_clr = 1'b1;
                end
            endcase
        end
    end

    assign pulse_d = link_en && in_lock && !trip && !seen_q &&
                     cls.clean_data && lmfc_edge;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_n_q <= 1'b0;
            locked_q <= 1'b0;
            ilas_q   <= 1'b0;
            seen_q   <= 1'b0;
        end else begin
            sync_n_q <= (state_d == ST_LOCKED);
            locked_q <= (state_d == ST_LOCKED);
            ilas_q   <= pulse_d;
            if (state_d != ST_LOCKED || !in_lock) begin
                seen_q <= 1'b0;
            end else if (pulse_d) begin
                seen_q <= 1'b1;
            end
        end
    end

    assign sync_n     = sync_n_q;
    assign cgs_locked = locked_q;
    assign ilas_start = ilas_q;
endmodule

// File: rtl/cgs_lane_sync_chk.sv
module cgs_lane_sync_chk #(
    parameter int NEED  = 4,
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_en,
    input logic [7:0]       rx_char,
    input logic             rx_ctrl,
    input logic             rx_err,
    input logic             lmfc_edge,
    input logic             sync_n,
    input logic             cgs_locked,
    input logic             ilas_start,
    input logic [ERR_W-1:0] err_count
);
    logic       is_comma;
    logic [7:0] run_c;

    assign is_comma = rx_ctrl && (rx_char == 8'hBC) && !rx_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_c <= '0;
        end else if (!link_en || !is_comma) begin
            run_c <= '0;
        end else if (run_c != 8'hFF) begin
            run_c <= run_c + 8'd1;
        end
    end

    p_disable_requests_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (!sync_n && !cgs_locked && !ilas_start));

    // R2 and R3: release only after a full comma run
    p_release_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> (run_c >= 8'(NEED)));

    p_hold_on_comma_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cgs_locked && link_en && is_comma) |=> cgs_locked);

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ilas_start |=> !ilas_start);

    p_pulse_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ilas_start) |-> ($past(lmfc_edge) && $past(cgs_locked)));

    p_err_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && rx_err && (err_count != {ERR_W{1'b1}}))
            |=> (err_count == $past(err_count) + 1'b1));

    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_en || !rx_err) |=> $stable(err_count));
endmodule

bind cgs_lane_sync cgs_lane_sync_chk #(.NEED(NEED), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/test_cgs_lane_sync.sv
module test_cgs_lane_sync;
    localparam int CLK_PERIOD = 10;
    localparam int EW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          link_en = 1'b0;
    logic [7:0]    rx_char = 8'h00;
    logic          rx_ctrl = 1'b0;
    logic          rx_err = 1'b0;
    logic          lmfc_edge = 1'b0;
    logic          sync_n, cgs_locked, ilas_start;
    logic [EW-1:0] err_count;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model
    int   m_state = 0;
    int   m_run = 0;
    logic [2:0] m_hist = '0;
    logic m_seen = 0;
    logic m_ilas = 0;
    int   m_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cgs_lane_sync #(.ERR_W(EW)) i_cgs_lane_sync (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .rx_char(rx_char),
        .rx_ctrl(rx_ctrl), .rx_err(rx_err), .lmfc_edge(lmfc_edge),
        .sync_n(sync_n), .cgs_locked(cgs_locked), .ilas_start(ilas_start),
        .err_count(err_count)
    );

    function automatic logic is_comma_f(logic [7:0] c, logic k, logic e);
        return k && (c == 8'hBC) && !e;
    endfunction

    function automatic int ones3(logic [2:0] h);
        return int'(h[0]) + int'(h[1]) + int'(h[2]);
    endfunction

    task automatic model_step();
        logic cm;
        int   hits;
        cm = is_comma_f(rx_char, rx_ctrl, rx_err);
        if (link_en && rx_err && m_err < (2**EW - 1)) m_err++;
        m_ilas = 0;
        if (!link_en) begin
            m_state = 0; m_run = 0; m_hist = '0; m_seen = 0;
        end else if (m_state != 2) begin
            if (cm) begin
                if (m_run == 3) begin
                    m_state = 2; m_run = 0; m_hist = '0; m_seen = 0;
                end else begin
                    m_state = 1; m_run++;
                end
            end else begin
                m_state = 0; m_run = 0;
            end
        end else begin
            hits = ones3(m_hist) + int'(rx_err);
            if (hits >= 3) begin
                m_state = 0; m_hist = '0; m_seen = 0;
            end else begin
                m_hist = {m_hist[1:0], rx_err};
                if (!m_seen && !rx_err && !cm && !(rx_ctrl && rx_char == 8'hBC)
                    && lmfc_edge) begin
                    m_ilas = 1; m_seen = 1;
                end
            end
        end
    endtask

    task automatic check(string tag, string what, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "sync_n", int'(sync_n), (m_state == 2) ? 1 : 0);
        check(tag, "cgs_locked", int'(cgs_locked), (m_state == 2) ? 1 : 0);
        check(tag, "ilas_start", int'(ilas_start), int'(m_ilas));
        check(tag, "err_count", int'(err_count), m_err);
    endtask

    task automatic drive(logic [7:0] c, logic k, logic e, logic b, string tag);
        rx_char = c; rx_ctrl = k; rx_err = e; lmfc_edge = b;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic commas(int n, string tag);
        for (int i = 0; i < n; i++) drive(8'hBC, 1'b1, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", "sync_n at reset", int'(sync_n), 0);
        check("R1", "err_count at reset", int'(err_count), 0);
        rst_n = 1'b1;
        link_en = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R3: three commas then data does not release
        commas(3, "R3");
        check("R3", "sync_n after 3 commas", int'(sync_n), 0);
        // R4: data character restarts the run
        drive(8'h55, 1'b0, 1'b0, 1'b0, "R4");
        commas(3, "R4");
        check("R4", "no lock after restarted run of 3", int'(sync_n), 0);
        // R2: 0xBC without control flag is not a comma
        drive(8'hBC, 1'b0, 1'b0, 1'b0, "R2");
        // R2: error-flagged comma byte is not a comma
        commas(2, "R2");
        drive(8'hBC, 1'b1, 1'b1, 1'b0, "R2");
        check("R2", "no lock across error comma", int'(sync_n), 0);
        // R3: four clean commas release
        commas(4, "R3");
        check("R3", "sync_n after 4 commas", int'(sync_n), 1);
        // R5: commas and data keep lock; off-boundary data gives no pulse (R7)
        commas(5, "R5");
        drive(8'h12, 1'b0, 1'b0, 1'b0, "R7");
        check("R7", "no pulse off boundary", int'(ilas_start), 0);
        drive(8'h1C, 1'b1, 1'b0, 1'b1, "R7");
        check("R7", "pulse on boundary", int'(ilas_start), 1);
        drive(8'h34, 1'b0, 1'b0, 1'b1, "R7");
        check("R7", "single pulse per lock", int'(ilas_start), 0);
        // R6: two errors in four keep lock
        drive(8'h00, 1'b0, 1'b1, 1'b0, "R6");
        drive(8'h00, 1'b0, 1'b0, 1'b0, "R6");
        drive(8'h00, 1'b0, 1'b0, 1'b0, "R6");
        drive(8'h00, 1'b0, 1'b1, 1'b0, "R6");
        check("R6", "two errors keep lock", int'(sync_n), 1);
        drive(8'h00, 1'b0, 1'b1, 1'b0, "R6");
        drive(8'h00, 1'b0, 1'b1, 1'b0, "R6");
        check("R6", "three of four drop lock", int'(sync_n), 0);
        // R8: saturation of error count
        for (int i = 0; i < 20; i++) drive(8'h00, 1'b0, 1'b1, 1'b0, "R8");
        check("R8", "saturated count", int'(err_count), 2**EW - 1);
        // R1: enable low returns to hunt and holds the count
        commas(4, "R3");
        link_en = 1'b0;
        drive(8'h00, 1'b0, 1'b1, 1'b0, "R1");
        check("R1", "sync_n with link disabled", int'(sync_n), 0);
        link_en = 1'b1;

        // reset clears the count (R1), then random traffic
        rst_n = 1'b0;
        @(negedge clk);
        m_state = 0; m_run = 0; m_hist = '0; m_seen = 0; m_ilas = 0; m_err = 0;
        rst_n = 1'b1;
        check_all("R1");
        for (int i = 0; i < 4000; i++) begin
            r = int'($urandom_range(0, 99));
            link_en = ($urandom_range(0, 199) != 0);
            if (r < 70)
                drive(8'hBC, 1'b1, 1'b0, (i % 8) == 0, "R5");
            else if (r < 85)
                drive(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
                      1'b0, (i % 8) == 0, "R7");
            else
                drive(8'($urandom_range(0, 255)), 1'b0, 1'b1, (i % 8) == 0, "R6");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule